// File: doc/BRIEF.md
# Run-Time Configurable Serial Character Transceiver

This block sends and receives asynchronous serial characters for a CPU. The CPU writes one byte into a transmit holding register, and the block frames it on the serial output line. Each received frame becomes a byte in a receive holding register, which the CPU later reads. Each direction has one holding register, so the CPU sees the transmit side as a single slot and the receive side as a single mailbox. Status outputs tell the CPU when it may write, when the transmitter has gone completely quiet, and when a received byte is waiting.

Bit timing comes from an internal divider. It produces an oversampling tick once every `divisor + 1` clocks, and one bit lasts sixteen ticks. A six-bit frame-format register sets three things at run time: the character length (5 to 8 data bits), the parity (none, even or odd) and the stop length (1, 1.5 or 2 bits). The 1.5-bit stop is timed in half-bit steps of eight ticks. The receiver samples every bit at its centre. It rejects a start edge that does not last, and it reports parity, framing and overrun conditions for each character.

Top module: `serial_xcvr`

## Requirements
- R1: An oversampling tick occurs once every `divisor + 1` clocks, and every transmitted bit lasts 16 ticks. A transmitted frame is one low start bit, then the data bits least significant first, then the optional parity bit, then a high stop level. While idle, the line stays high.
- R2: `modeIn[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low bits of the written byte are transmitted.
- R3: `modeIn[3:2]` sets the parity: 01 is even, 10 is odd, and 00 or 11 is none. With even parity, the parity bit makes the count of ones over the data bits and the parity bit even. With odd parity, it makes that count odd.
- R4: `modeIn[5:4]` sets the stop length: 00 gives 16 ticks, 01 gives 24 ticks and 10 or 11 gives 32 ticks. If a byte is already held when the stop period ends, its start bit begins on that same tick, with no idle gap.
- R5: `txReady` is high exactly when the transmit holding register is free. The register frees on the tick that starts a frame. A `txWr` while `txReady` is low is ignored.
- R6: `txEmpty` is high only when no byte is held and no frame is being sent. The line is high whenever `txEmpty` is high.
- R7: `rxReady` rises when a received character is stored. An `rxRd` pulse clears it on the next clock.
- R8: Received bits are assembled least significant first. Data bit positions above the configured length read as 0 in `rxData`.
- R9: A start bit that is no longer low when the receiver samples it at mid-bit is discarded. Nothing is stored, and a later valid frame is still received correctly.
- R10: `parityErr` is set for a received character whose parity bit does not match the configured parity. It is cleared for a character whose parity bit matches.
- R11: `frameErr` is set for a received character whose first stop bit is sampled low. It changes only when a character is stored.
- R12: `overrunErr` is set when a character is stored while the previous one is still unread. The new character replaces the old one in `rxData`.
- R13: A write to the frame-format register takes effect only while `txEmpty` is high. At any other time the write is ignored.
- R14: After reset, `txOut`, `txReady` and `txEmpty` are 1, `rxReady` and all three error flags are 0, and the format is 8 data bits, no parity and 1 stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Tick period minus one, in clocks |
| modeWr | input | 1 | Write strobe for the frame-format register |
| modeIn | input | 6 | Format value: stop [5:4], parity [3:2], length [1:0] |
| txWr | input | 1 | Write strobe for the transmit byte |
| txData | input | 8 | Byte to transmit |
| rxRd | input | 1 | Read strobe that consumes the received byte |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| txReady | output | 1 | Transmit holding register is free |
| txEmpty | output | 1 | Transmitter is fully idle |
| rxData | output | 8 | Last received byte, zero-extended |
| rxReady | output | 1 | Received byte is waiting |
| parityErr | output | 1 | Parity mismatch on the last character |
| frameErr | output | 1 | Low stop bit on the last character |
| overrunErr | output | 1 | Last character overwrote an unread one |

## Verification
The checks assume three things about the inputs. The format register and `divisor` are changed only while both directions are idle. An `rxRd` pulse never lands in the same clock as the store of a new character. Incoming frames hold each bit level for exactly sixteen ticks. The stimulus follows these rules. It reprograms the format and the divisor only after `txEmpty` has returned and the last received frame has ended. It drives each `rxIn` level for `16 * (divisor + 1)` clocks. It pulses `rxRd` several clocks after a frame's stop bit has finished. One deliberate exception is a format write made in the middle of a transmitted frame, which is there to show that such a write is ignored.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

  localparam int MAX_BITS = 8;   // widest character
  localparam int OS_RATE  = 16;  // ticks per bit

  typedef struct packed {
    logic [1:0] stopSel;
    logic [1:0] parSel;
    logic [1:0] lenSel;
  } frameMode_t;

  typedef enum logic [1:0] {SEL_START, SEL_DATA, SEL_PAR, SEL_STOP} txSel_e;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} lineState_e;

  typedef struct packed {
    logic   txLoad;
    logic   txStep;
    txSel_e txSel;
    logic   rxSample;
    logic   rxIsPar;
    logic   rxFinish;
  } strobes_t;

  function automatic logic [3:0] dataBits(frameMode_t m);
    return 4'd5 + {2'b00, m.lenSel};
  endfunction

  function automatic logic parOn(frameMode_t m);
    return (m.parSel == 2'b01) || (m.parSel == 2'b10);
  endfunction

  // last tick index of the stop period: 1, 1.5 or 2 bits
  function automatic logic [4:0] stopLast(frameMode_t m);
    case (m.stopSel)
      2'b00:   return 5'(OS_RATE - 1);
      2'b01:   return 5'(OS_RATE + OS_RATE / 2 - 1);
      default: return 5'(2 * OS_RATE - 1);
    endcase
  endfunction

  function automatic logic parBit(logic [MAX_BITS-1:0] d, frameMode_t m);
    logic [MAX_BITS-1:0] mask;
    mask = {MAX_BITS{1'b1}} >> (4'(MAX_BITS) - dataBits(m));
    return (^(d & mask)) ^ (m.parSel == 2'b10);
  endfunction

endpackage

// File: rtl/serial_xcvr_ctrl.sv
module serial_xcvr_ctrl
  import serial_xcvr_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             modeWr,
  input  frameMode_t       modeReq,
  input  logic             rxIn,
  input  logic             holdFull,
  output frameMode_t       mode,
  output logic             rxSync,
  output strobes_t         stb,
  output logic             txEmpty
);

  localparam logic [3:0] RX_MID  = 4'(OS_RATE / 2 - 1);
  localparam logic [3:0] RX_LAST = 4'(OS_RATE - 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [1:0]       rxPipe;

  lineState_e txState, txNext, rxState, rxNext;
  logic [4:0] txCnt, txCntNext, txLast;
  logic [2:0] txBit, txBitNext, rxBit, rxBitNext;
  logic [3:0] rxCnt, rxCntNext, lastBit;
  logic       load, step, sample, isPar, finish;
  txSel_e     sel;

  assign tick    = (divCnt >= divisor);
  assign rxSync  = rxPipe[1];
  assign txEmpty = (txState == ST_IDLE) && !holdFull;
  assign lastBit = dataBits(mode) - 4'd1;
  assign txLast  = (txState == ST_STOP) ? stopLast(mode) : 5'(OS_RATE - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      rxPipe  <= 2'b11;
      mode    <= '{stopSel: 2'b00, parSel: 2'b00, lenSel: 2'b11};
      txState <= ST_IDLE;
      txCnt   <= '0;
      txBit   <= '0;
      rxState <= ST_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
    end else begin
      divCnt  <= tick ? '0 : divCnt + 1'b1;
      rxPipe  <= {rxPipe[0], rxIn};
      if (modeWr && txEmpty) mode <= modeReq;
      txState <= txNext;
      txCnt   <= txCntNext;
      txBit   <= txBitNext;
      rxState <= rxNext;
      rxCnt   <= rxCntNext;
      rxBit   <= rxBitNext;
    end
  end

  // transmit sequencing
  always_comb begin
    txNext    = txState;
    txCntNext = txCnt;
    txBitNext = txBit;
    load      = 1'b0;
    step      = 1'b0;
    sel       = SEL_STOP;
    if (tick) begin
      if (txState == ST_IDLE) begin
        if (holdFull) begin
          load = 1'b1; step = 1'b1; sel = SEL_START;
          txNext = ST_START; txCntNext = '0;
        end
      end else if (txCnt != txLast) begin
        txCntNext = txCnt + 5'd1;
      end else begin
        txCntNext = '0;
        case (txState)
          ST_START: begin
            step = 1'b1; sel = SEL_DATA; txNext = ST_DATA; txBitNext = '0;
          end
          ST_DATA: begin
            step = 1'b1;
            if ({1'b0, txBit} == lastBit) begin
              if (parOn(mode)) begin sel = SEL_PAR;  txNext = ST_PAR;  end
              else             begin sel = SEL_STOP; txNext = ST_STOP; end
            end else begin
              sel = SEL_DATA; txBitNext = txBit + 3'd1;
            end
          end
          ST_PAR: begin
            step = 1'b1; sel = SEL_STOP; txNext = ST_STOP;
          end
          default: begin
            if (holdFull) begin
              load = 1'b1; step = 1'b1; sel = SEL_START; txNext = ST_START;
            end else begin
              txNext = ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  // receive sequencing, centre sampling
  always_comb begin
    rxNext    = rxState;
    rxCntNext = rxCnt;
    rxBitNext = rxBit;
    sample    = 1'b0;
    isPar     = 1'b0;
    finish    = 1'b0;
    if (tick) begin
      case (rxState)
        ST_IDLE: if (!rxSync) begin rxNext = ST_START; rxCntNext = '0; end
        ST_START: begin
          if (rxCnt != RX_MID) rxCntNext = rxCnt + 4'd1;
          else begin
            rxCntNext = '0; rxBitNext = '0;
            rxNext = rxSync ? ST_IDLE : ST_DATA;
          end
        end
        default: begin
          if (rxCnt != RX_LAST) rxCntNext = rxCnt + 4'd1;
          else begin
            rxCntNext = '0;
            case (rxState)
              ST_DATA: begin
                sample = 1'b1;
                if ({1'b0, rxBit} == lastBit) rxNext = parOn(mode) ? ST_PAR : ST_STOP;
                else rxBitNext = rxBit + 3'd1;
              end
              ST_PAR: begin sample = 1'b1; isPar = 1'b1; rxNext = ST_STOP; end
              default: begin finish = 1'b1; rxNext = ST_IDLE; end
            endcase
          end
        end
      endcase
    end
  end

  assign stb = '{txLoad: load, txStep: step, txSel: sel,
                 rxSample: sample, rxIsPar: isPar, rxFinish: finish};

  // R13
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeWr && !txEmpty |=> $stable(mode));

endmodule

// File: rtl/serial_xcvr_dp.sv
module serial_xcvr_dp
  import serial_xcvr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  frameMode_t          mode,
  input  logic                rxSync,
  input  logic                txWr,
  input  logic [MAX_BITS-1:0] txData,
  input  logic                rxRd,
  output logic                holdFull,
  output logic                txOut,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxReady,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrunErr
);

  logic [MAX_BITS-1:0] holdReg, shTx, rxSh, rxWord;
  logic                txParBit, rxParBit;

  assign rxWord = rxSh >> (4'(MAX_BITS) - dataBits(mode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shTx     <= '0;
      txParBit <= 1'b0;
      txOut    <= 1'b1;
    end else begin
      if (stb.txLoad) begin
        holdFull <= 1'b0;
        shTx     <= holdReg;
        txParBit <= parBit(holdReg, mode);
      end
      if (txWr && !holdFull) begin
        holdReg  <= txData;
        holdFull <= 1'b1;
      end
      if (stb.txStep) begin
        case (stb.txSel)
          SEL_START: txOut <= 1'b0;
          SEL_DATA:  begin txOut <= shTx[0]; shTx <= shTx >> 1; end
          SEL_PAR:   txOut <= txParBit;
          default:   txOut <= 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxParBit   <= 1'b0;
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (stb.rxSample) begin
        if (stb.rxIsPar) rxParBit <= rxSync;
        else             rxSh     <= {rxSync, rxSh[MAX_BITS-1:1]};
      end
      if (stb.rxFinish) begin
        rxData     <= rxWord;
        rxReady    <= 1'b1;
        frameErr   <= !rxSync;
        parityErr  <= parOn(mode) && (rxParBit != parBit(rxWord, mode));
        overrunErr <= rxReady && !rxRd;
      end else if (rxRd) begin
        rxReady <= 1'b0;
      end
    end
  end

  // R5
  full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    txWr && holdFull |=> $stable(holdReg));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxRd && !stb.rxFinish |=> !rxReady);

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rxFinish |=> $stable(frameErr));

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_xcvr_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             modeWr,
  input  logic [5:0]       modeIn,
  input  logic             txWr,
  input  logic [7:0]       txData,
  input  logic             rxRd,
  input  logic             rxIn,
  output logic             txOut,
  output logic             txReady,
  output logic             txEmpty,
  output logic [7:0]       rxData,
  output logic             rxReady,
  output logic             parityErr,
  output logic             frameErr,
  output logic             overrunErr
);

  frameMode_t modeReq, mode;
  strobes_t   stb;
  logic       holdFull, rxSync;

  assign modeReq = modeIn;
  assign txReady = !holdFull;

  serial_xcvr_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .modeWr(modeWr),
    .modeReq(modeReq), .rxIn(rxIn), .holdFull(holdFull), .mode(mode),
    .rxSync(rxSync), .stb(stb), .txEmpty(txEmpty)
  );

  serial_xcvr_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode), .rxSync(rxSync),
    .txWr(txWr), .txData(txData), .rxRd(rxRd), .holdFull(holdFull),
    .txOut(txOut), .rxData(rxData), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  // R6
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txOut);

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOut) |-> !txEmpty);

endmodule

// File: tb/serial_xcvr_bench.sv
module serial_xcvr_bench;
  localparam int DIV_W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [DIV_W-1:0] divisor = 16'd1;
  logic modeWr = 1'b0, txWr = 1'b0, rxRd = 1'b0, rxIn = 1'b1;
  logic [5:0] modeIn = '0;
  logic [7:0] txData = '0;
  logic txOut, txReady, txEmpty, rxReady, parityErr, frameErr, overrunErr;
  logic [7:0] rxData;

  serial_xcvr #(.DIV_W(DIV_W)) u_serial_xcvr (
    .clk(clk), .rstN(rstN), .divisor(divisor), .modeWr(modeWr), .modeIn(modeIn),
    .txWr(txWr), .txData(txData), .rxRd(rxRd), .rxIn(rxIn), .txOut(txOut),
    .txReady(txReady), .txEmpty(txEmpty), .rxData(rxData), .rxReady(rxReady),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int divVal = 1;
  int curN = 8, curP = 0, curS = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int bitClk();
    return 16 * (divVal + 1);
  endfunction

  function automatic int stopT(int s);
    return (s == 0) ? 16 : (s == 1) ? 24 : 32;
  endfunction

  function automatic bit parOf(logic [7:0] d, int n, int p);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    return (p == 2) ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  function automatic logic [5:0] mk(int n, int p, int s);
    return {2'(s), 2'(p), 2'(n - 5)};
  endfunction

  task automatic pokeMode(input logic [5:0] v);
    @(negedge clk); modeWr = 1'b1; modeIn = v;
    @(negedge clk); modeWr = 1'b0;
  endtask

  task automatic setMode(input int n, input int p, input int s);
    pokeMode(mk(n, p, s));
    curN = n; curP = p; curS = s;
  endtask

  task automatic writeNow(input logic [7:0] d);
    txWr = 1'b1; txData = d;
    @(negedge clk); txWr = 1'b0;
  endtask

  task automatic waitFall();
    do @(negedge clk); while (txOut !== 1'b0);
  endtask

  // per-clock comparison of the line against the expected frame,
  // starting at the first negedge where the start bit is visible
  task automatic frameCheck(input logic [7:0] d, input string tag);
    int lv[12];
    int nb = 1 + curN + ((curP == 1 || curP == 2) ? 1 : 0);
    int total = (16 * nb + stopT(curS)) * (divVal + 1);
    int badK = -1, badV = 0, badE = 0;
    lv[0] = 0;
    for (int i = 0; i < curN; i++) lv[1 + i] = int'(d[i]);
    if (nb > 1 + curN) lv[1 + curN] = int'(parOf(d, curN, curP));
    for (int k = 0; k < total; k++) begin
      int e;
      if (k > 0) @(negedge clk);
      e = (k / bitClk() < nb) ? lv[k / bitClk()] : 1;
      if (int'(txOut) != e && badK < 0) begin badK = k; badV = int'(txOut); badE = e; end
    end
    check(badK < 0, tag, $sformatf("tx line level at offset %0d", badK), badV, badE);
  endtask

  task automatic rxSend(input logic [7:0] d, input bit flipPar, input bit stopVal);
    int bc = bitClk();
    rxIn = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < curN; i++) begin rxIn = d[i]; repeat (bc) @(negedge clk); end
    if (curP == 1 || curP == 2) begin
      rxIn = parOf(d, curN, curP) ^ flipPar; repeat (bc) @(negedge clk);
    end
    rxIn = stopVal; repeat (bc) @(negedge clk);
    rxIn = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic readRx(input string tag);
    rxRd = 1'b1; @(negedge clk); rxRd = 1'b0;
    check(rxReady == 1'b0, tag, "rxReady after read", int'(rxReady), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run incomplete)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int extra;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R14 reset state
    check(txOut == 1'b1, "R14", "txOut", int'(txOut), 1);
    check(txReady == 1'b1 && txEmpty == 1'b1, "R14", "txReady&txEmpty", int'(txReady & txEmpty), 1);
    check(rxReady == 1'b0, "R14", "rxReady", int'(rxReady), 0);
    check({parityErr, frameErr, overrunErr} == 3'b000, "R14", "error flags",
          int'({parityErr, frameErr, overrunErr}), 0);

    // R1 R14: default 8N1 frame
    writeNow(8'hA5);
    waitFall();
    check(txReady == 1'b1, "R5", "txReady once frame starts", int'(txReady), 1);
    check(txEmpty == 1'b0, "R6", "txEmpty during frame", int'(txEmpty), 0);
    frameCheck(8'hA5, "R1");
    repeat (4) @(negedge clk);
    check(txEmpty == 1'b1, "R6", "txEmpty after frame", int'(txEmpty), 1);

    // R2 R3: 5 bits, even parity, 2 stop
    setMode(5, 1, 2);
    @(negedge clk);
    writeNow(8'hF3);
    waitFall();
    frameCheck(8'hF3, "R2");

    // R13: format write during a frame is ignored
    @(negedge clk);
    writeNow(8'h3C);
    waitFall();
    fork
      pokeMode(mk(8, 0, 0));
      frameCheck(8'h3C, "R13");
    join
    repeat (4) @(negedge clk);
    writeNow(8'h0F);
    waitFall();
    frameCheck(8'h0F, "R13");

    // R3 R4: 7 bits, odd parity, 1.5 stop, back-to-back, R5 ignored write
    repeat (4) @(negedge clk);
    setMode(7, 2, 1);
    @(negedge clk);
    writeNow(8'h55);
    waitFall();
    fork
      begin
        writeNow(8'h2A);
        check(txReady == 1'b0, "R5", "txReady while held", int'(txReady), 0);
        writeNow(8'hFF);
      end
      frameCheck(8'h55, "R3");
    join
    @(negedge clk);
    check(txOut == 1'b0, "R4", "next start right after 1.5 stop", int'(txOut), 0);
    frameCheck(8'h2A, "R5");
    extra = 0;
    repeat (3 * bitClk()) begin
      @(negedge clk);
      if (txOut !== 1'b1) extra++;
    end
    check(extra == 0, "R5", "low cycles after last frame", extra, 0);
    check(txEmpty == 1'b1, "R6", "txEmpty idle", int'(txEmpty), 1);

    // R1: slower divisor, 6 bits, no parity (code 11), 1 stop
    divisor = 16'd2; divVal = 2;
    setMode(6, 3, 0);
    @(negedge clk);
    writeNow(8'h15);
    waitFall();
    frameCheck(8'h15, "R1");
    repeat (8) @(negedge clk);
    divisor = 16'd1; divVal = 1;

    // R7 R8: receive 8N1
    setMode(8, 0, 0);
    @(negedge clk);
    rxSend(8'hC6, 1'b0, 1'b1);
    check(rxReady == 1'b1, "R7", "rxReady after frame", int'(rxReady), 1);
    check(rxData == 8'hC6, "R8", "rxData 8 bits", int'(rxData), 'hC6);
    check({parityErr, frameErr, overrunErr} == 3'b000, "R10", "flags clean frame",
          int'({parityErr, frameErr, overrunErr}), 0);
    readRx("R7");

    // R8: 5 bits, even parity, upper bits zero
    setMode(5, 1, 0);
    @(negedge clk);
    rxSend(8'hFB, 1'b0, 1'b1);
    check(rxData == 8'h1B, "R8", "rxData upper bits zero", int'(rxData), 'h1B);
    check(parityErr == 1'b0, "R10", "good parity", int'(parityErr), 0);
    readRx("R7");

    // R10: bad parity
    rxSend(8'h0A, 1'b1, 1'b1);
    check(parityErr == 1'b1, "R10", "parity mismatch", int'(parityErr), 1);
    check(rxData == 8'h0A, "R10", "data with bad parity", int'(rxData), 'h0A);
    readRx("R7");

    // R11: low stop bit
    rxSend(8'h13, 1'b0, 1'b0);
    check(frameErr == 1'b1, "R11", "framing error", int'(frameErr), 1);
    repeat (2 * bitClk()) @(negedge clk);
    readRx("R7");

    // R9: short low pulse rejected, then a valid frame
    rxIn = 1'b0; repeat (4 * (divVal + 1)) @(negedge clk);
    rxIn = 1'b1; repeat (3 * bitClk()) @(negedge clk);
    check(rxReady == 1'b0, "R9", "glitch stored nothing", int'(rxReady), 0);
    rxSend(8'h07, 1'b0, 1'b1);
    check(rxReady == 1'b1 && rxData == 8'h07, "R9", "frame after glitch", int'(rxData), 'h07);
    check(frameErr == 1'b0, "R11", "framing flag clears", int'(frameErr), 0);

    // R12: overrun, new byte replaces old
    setMode(8, 0, 0);
    @(negedge clk);
    rxSend(8'h5A, 1'b0, 1'b1);
    check(overrunErr == 1'b1, "R12", "overrun set", int'(overrunErr), 1);
    check(rxData == 8'h5A, "R12", "newest byte kept", int'(rxData), 'h5A);
    readRx("R7");
    rxSend(8'h81, 1'b0, 1'b1);
    check(overrunErr == 1'b0, "R12", "overrun clear after read", int'(overrunErr), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule